// File: doc/BRIEF.md
# Flow-Controlled SPI Host Controller

This block is an SPI host with a small 32-bit register interface. Software fills a transmit byte queue, writes a start word that holds a byte count and two direction enables, and later drains a receive byte queue. Each byte is clocked out in SPI mode 0, most significant bit first. The serial clock is a divided copy of the system clock.

The engine checks the queues before every byte. It waits while transmit is enabled and the transmit queue is empty, or while receive is enabled and the receive queue is full. While it waits, the serial clock stays low and the transfer stays in progress. Software can therefore issue the start word before any data or receive space exists.

Active-low chip-select lines come straight from a chip-select register. The controller keeps that register frozen while a transfer is in progress. An info register reports the depth of each queue.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset all chip-select outputs are high, the serial clock is low, and the status word reads 0. The chip-select register at 0x28 reads all ones.
- R2: A write to 0x20 pushes its bits 7:0 into the transmit queue, which holds 8 bytes. A push to a full queue is dropped and the level stays at 8.
- R3: A read of 0x1C returns the oldest received byte and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R4: Bytes are shifted most significant bit first in SPI mode 0. The output data line is stable at every rising serial clock edge, and the input line is sampled on that edge. With the output looped back to the input, each received byte equals the byte sent.
- R5: While transmit is enabled and the transmit queue is empty, the transfer stays busy with the serial clock held low. It resumes once a byte is pushed.
- R6: While receive is enabled and the receive queue is full, the transfer stays busy with the serial clock held low. It resumes once a byte is read out.
- R7: The start register at 0x18 takes a byte count in bits 7:0, transmit-enable in bit 16 and receive-enable in bit 17. A count of 0 starts nothing. With transmit disabled the output line sends zeros, and with receive disabled nothing is stored.
- R8: A write to the start register while a transfer is in progress is ignored.
- R9: A write to the chip-select register at 0x28 while idle drives its low 4 bits, active low, onto the chip-select outputs. Writes during a transfer are ignored.
- R10: The info register at 0x24 reads the transmit queue depth in bits 7:0 and the receive queue depth in bits 15:8, which is 0x0808 by default.
- R11: The status register at 0x14 holds busy in bit 0, the transmit level in bits 11:8 and the receive level in bits 19:16.
- R12: The configuration register at 0x0C holds a divider D in bits 7:0. Each high phase and each low phase of the serial clock lasts D+1 system clocks.
- R13: A write to the control register at 0x10 empties the transmit queue when bit 0 is set and empties the receive queue when bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to peripherals |
| miso_i | input | 1 | Serial data from peripherals |
| cs_no | output | NUM_CS | Active-low chip selects |

## Verification
The assertions check several rules on every cycle:
- No byte is stored into a full receive queue.
- Overfilling or overdraining a queue never moves its level past its bounds.
- The serial clock holds its level between divider ticks and is low whenever the controller is idle.
- Neither the chip-select register nor the start logic reacts during a transfer.

Only the bench scenarios can show the end-to-end results:
- Bit order and the loopback data.
- That a stalled transfer picks up again once data or space appears.
- The register encodings, the phase lengths the divider produces, and the effect of the queue flushes.

// File: rtl/spi_host_pkg.sv
// Shared register offsets and engine state encoding for the SPI host.
// Assumes byte-granular offsets on an 8-bit address.
package spi_host_pkg;
    localparam logic [7:0] OFS_CFG   = 8'h0C;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_START = 8'h18;
    localparam logic [7:0] OFS_RXD   = 8'h1C;
    localparam logic [7:0] OFS_TXD   = 8'h20;
    localparam logic [7:0] OFS_INFO  = 8'h24;
    localparam logic [7:0] OFS_CSEL  = 8'h28;

    localparam int START_TX_BIT = 16;
    localparam int START_RX_BIT = 17;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
// Byte queue with level output. A push when full and a pop when empty are
// dropped. Clear empties the queue and wins over push and pop.
// Assumes DEPTH >= 2; DEPTH need not be a power of two.
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o,
    output logic [LVL_W-1:0] level_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] lvl_q;
    logic do_push, do_pop;

    assign full_o  = (lvl_q == LVL_W'(DEPTH));
    assign empty_o = (lvl_q == '0);
    assign level_o = lvl_q;
    assign head_o  = mem_q[rp_q];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push && !clear_i) mem_q[wp_q] <= wdata_i;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
            else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clear_i) |=> (level_o == $past(level_o)));
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clear_i) |=> empty_o);
endmodule

// File: rtl/spi_shift_engine.sv
// Mode-0 shift engine. It checks queue readiness before every byte, shifts
// MSB first, samples input on rising edges and shifts on falling edges.
// Assumes the divider is changed only while idle.
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tx_empty_i,
    input  logic [7:0]       tx_data_i,
    output logic             tx_pop_o,
    input  logic             rx_full_i,
    output logic             rx_push_o,
    output logic [7:0]       rx_data_o,
    output logic             busy_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    eng_state_e       state_q;
    logic [CNT_W-1:0] remain_q;
    logic             tx_en_q, rx_en_q, sclk_q;
    logic [DIV_W-1:0] div_cnt_q;
    logic [2:0]       bit_q;
    logic [7:0]       txsh_q, rxsh_q;
    logic             can_go, tick, byte_end;

    assign can_go   = (!tx_en_q || !tx_empty_i) && (!rx_en_q || !rx_full_i);
    assign tick     = (div_cnt_q >= div_i);
    assign byte_end = (state_q == ENG_RUN) && tick && sclk_q && (bit_q == 3'd7);

    assign tx_pop_o  = (state_q == ENG_WAIT) && can_go && tx_en_q;
    assign rx_push_o = byte_end && rx_en_q;
    assign rx_data_o = rxsh_q;
    assign busy_o    = (state_q != ENG_IDLE);
    assign sclk_o    = sclk_q;
    assign mosi_o    = txsh_q[7];

    // Sequencer: idle, wait for queue readiness, run eight bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ENG_IDLE;
            remain_q  <= '0;
            tx_en_q   <= 1'b0;
            rx_en_q   <= 1'b0;
            sclk_q    <= 1'b0;
            div_cnt_q <= '0;
            bit_q     <= '0;
            txsh_q    <= '0;
            rxsh_q    <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: if (start_i) begin
                    remain_q <= cnt_i;
                    tx_en_q  <= tx_en_i;
                    rx_en_q  <= rx_en_i;
                    state_q  <= ENG_WAIT;
                end
                ENG_WAIT: if (can_go) begin
                    txsh_q    <= tx_en_q ? tx_data_i : 8'h00;
                    bit_q     <= '0;
                    div_cnt_q <= '0;
                    state_q   <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (!tick) begin
                        div_cnt_q <= div_cnt_q + 1'b1;
                    end else begin
                        div_cnt_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rxsh_q <= {rxsh_q[6:0], miso_i};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == 3'd7) begin
                                remain_q <= remain_q - 1'b1;
                                state_q  <= (remain_q == CNT_W'(1)) ? ENG_IDLE : ENG_WAIT;
                            end else begin
                                txsh_q <= {txsh_q[6:0], 1'b0};
                                bit_q  <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assert_rx_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> !rx_full_i);
    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_WAIT && tx_en_q && tx_empty_i) |=> (!sclk_o && busy_o));
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);
    assert_phase_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_RUN && !tick) |=> $stable(sclk_o));
endmodule

// File: rtl/spi_host_regs.sv
// Register decode. It holds the divider and the chip-select bits, turns
// accesses into queue strobes and start requests, and muxes read data.
// Assumes the strobes last one cycle per access.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [7:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              busy_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic [7:0]        rx_head_i,
    input  logic              rx_empty_i,
    output logic              tx_push_o,
    output logic [7:0]        tx_wdata_o,
    output logic              rx_pop_o,
    output logic              tx_clear_o,
    output logic              rx_clear_o,
    output logic              start_o,
    output logic [CNT_W-1:0]  start_cnt_o,
    output logic              start_tx_o,
    output logic              start_rx_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [NUM_CS-1:0] cs_no
);
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CS-1:0] cs_q;

    assign tx_push_o   = we_i && (addr_i == OFS_TXD);
    assign tx_wdata_o  = wdata_i[7:0];
    assign rx_pop_o    = re_i && (addr_i == OFS_RXD);
    assign tx_clear_o  = we_i && (addr_i == OFS_CTRL) && wdata_i[0];
    assign rx_clear_o  = we_i && (addr_i == OFS_CTRL) && wdata_i[1];
    assign start_cnt_o = wdata_i[CNT_W-1:0];
    assign start_tx_o  = wdata_i[START_TX_BIT];
    assign start_rx_o  = wdata_i[START_RX_BIT];
    assign start_o     = we_i && (addr_i == OFS_START) && !busy_i
                         && (wdata_i[CNT_W-1:0] != '0);
    assign div_o       = div_q;
    assign cs_no       = cs_q;

    // Configuration and chip-select storage; chip select frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cs_q  <= '1;
        end else if (we_i) begin
            if (addr_i == OFS_CFG)              div_q <= wdata_i[DIV_W-1:0];
            if (addr_i == OFS_CSEL && !busy_i)  cs_q  <= wdata_i[NUM_CS-1:0];
        end
    end

    // Read data mux.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_CFG:  rdata_o = 32'(div_q);
            OFS_STAT: rdata_o = 32'(busy_i) | (32'(tx_level_i) << 8) | (32'(rx_level_i) << 16);
            OFS_RXD:  rdata_o = rx_empty_i ? 32'h0 : 32'(rx_head_i);
            OFS_INFO: rdata_o = (32'(DEPTH) & 32'hFF) | ((32'(DEPTH) & 32'hFF) << 8);
            OFS_CSEL: rdata_o = 32'(cs_q);
            default:  rdata_o = '0;
        endcase
    end

    assert_cs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cs_no));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !start_o);
endmodule

// File: rtl/spi_host_ctrl.sv
// SPI host top: register decode, transmit and receive byte queues, and the
// shift engine. Assumes a synchronous active-low reset and single-cycle strobes.
module spi_host_ctrl #(
    parameter int FIFO_DEPTH = 8,
    parameter int NUM_CS     = 4,
    parameter int DIV_W      = 8,
    parameter int CNT_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [7:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_CS-1:0] cs_no
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             busy, start, start_tx, start_rx;
    logic [CNT_W-1:0] start_cnt;
    logic [DIV_W-1:0] div;
    logic             tx_push, tx_pop, tx_clear, tx_full, tx_empty;
    logic             rx_push, rx_pop, rx_clear, rx_full, rx_empty;
    logic [7:0]       tx_wdata, tx_head, rx_wdata, rx_head;
    logic [LVL_W-1:0] tx_level, rx_level;

    spi_host_regs #(
        .DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk_i), .rst_n(rst_ni), .we_i(reg_we_i), .re_i(reg_re_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .busy_i(busy), .tx_level_i(tx_level), .rx_level_i(rx_level),
        .rx_head_i(rx_head), .rx_empty_i(rx_empty),
        .tx_push_o(tx_push), .tx_wdata_o(tx_wdata), .rx_pop_o(rx_pop),
        .tx_clear_o(tx_clear), .rx_clear_o(rx_clear),
        .start_o(start), .start_cnt_o(start_cnt), .start_tx_o(start_tx),
        .start_rx_o(start_rx), .div_o(div), .cs_no(cs_no)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk(clk_i), .rst_n(rst_ni), .clear_i(tx_clear),
        .push_i(tx_push), .wdata_i(tx_wdata), .pop_i(tx_pop),
        .head_o(tx_head), .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_level)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk(clk_i), .rst_n(rst_ni), .clear_i(rx_clear),
        .push_i(rx_push), .wdata_i(rx_wdata), .pop_i(rx_pop),
        .head_o(rx_head), .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_level)
    );

    spi_shift_engine #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk_i), .rst_n(rst_ni), .start_i(start), .cnt_i(start_cnt),
        .tx_en_i(start_tx), .rx_en_i(start_rx), .div_i(div),
        .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
        .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_wdata),
        .busy_o(busy), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    assert_txq_unused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pop |-> !tx_empty);
endmodule

// File: tb/spi_host_ctrl_bench.sv
// Self-checking bench: a loopback vector table followed by directed tests.
module spi_host_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        sclk, mosi, miso, force_one = 1'b0;
    logic [3:0]  cs_n;
    logic [7:0]  cap = '0;
    int          n_chk = 0, n_bad = 0;

    localparam logic [31:0] TXB = 32'h1 << 16;
    localparam logic [31:0] RXB = 32'h1 << 17;
    localparam logic [7:0] VEC [6] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h5A};

    always #5 clk = ~clk;
    assign miso = force_one ? 1'b1 : mosi;

    spi_host_ctrl u_spi_host_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
    );

    // Capture output line at each rising serial clock edge.
    always @(posedge sclk) cap <= {cap[6:0], mosi};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h14, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", 32'(cs_n), 32'hF);
        check("R1 sclk", 32'(sclk), 32'h0);
        rd(8'h14, d); check("R1/R11 status", d, 32'h0);
        rd(8'h28, d); check("R1 cs reg", d, 32'hF);
        // R10 info
        rd(8'h24, d); check("R10 info", d, 32'h0808);
        // R3 empty read
        rd(8'h1C, d); check("R3 empty read", d, 32'h0);
        rd(8'h14, d); check("R3 empty read no effect", d, 32'h0);

        // R4 vector table: loopback, one byte each
        foreach (VEC[i]) begin
            wr(8'h20, 32'(VEC[i]));
            wr(8'h18, TXB | RXB | 32'd1);
            wait_idle();
            rd(8'h1C, d); check("R4 loopback", d, 32'(VEC[i]));
            check("R4 msb first", 32'(cap), 32'(VEC[i]));
        end

        // R4 multi-byte order
        wr(8'h20, 32'h11); wr(8'h20, 32'h22); wr(8'h20, 32'h33);
        wr(8'h18, TXB | RXB | 32'd3);
        wait_idle();
        rd(8'h1C, d); check("R4 order 0", d, 32'h11);
        rd(8'h1C, d); check("R4 order 1", d, 32'h22);
        rd(8'h1C, d); check("R4 order 2", d, 32'h33);

        // R5 stall on empty transmit queue; R8 and R9 while busy
        wr(8'h18, TXB | RXB | 32'd1);
        hi = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (sclk) hi++; end
        check("R5 sclk held", 32'(hi), 32'h0);
        rd(8'h14, d); check("R5/R11 busy", d, 32'h1);
        wr(8'h18, RXB | 32'd3);
        wr(8'h28, 32'h0);
        check("R9 cs frozen", 32'(cs_n), 32'hF);
        wr(8'h20, 32'h6C);
        wait_idle();
        rd(8'h14, d); check("R8 second start ignored", d, 32'h10000);
        rd(8'h1C, d); check("R5 resumed data", d, 32'h6C);

        // R9 chip select while idle
        wr(8'h28, 32'h5);
        check("R9 cs drive", 32'(cs_n), 32'h5);
        rd(8'h28, d); check("R9 cs readback", d, 32'h5);
        wr(8'h28, 32'hF);

        // R2 transmit overfill, R13 transmit flush
        for (int i = 0; i < 9; i++) wr(8'h20, 32'(i));
        rd(8'h14, d); check("R2 tx level caps at 8", d, 32'h800);
        wr(8'h10, 32'h1);
        rd(8'h14, d); check("R13 tx flush", d, 32'h0);

        // R6 stall on full receive queue, R7 tx disabled sends zeros
        force_one = 1'b1;
        wr(8'h18, RXB | 32'd9);
        repeat (300) @(negedge clk);
        rd(8'h14, d); check("R6 stalled full", d, 32'h80001);
        check("R6 sclk low", 32'(sclk), 32'h0);
        check("R7 zeros sent", 32'(cap), 32'h0);
        rd(8'h1C, d); check("R6 data", d, 32'hFF);
        wait_idle();
        rd(8'h14, d); check("R6 resumed", d, 32'h80000);
        force_one = 1'b0;
        wr(8'h10, 32'h2);
        rd(8'h14, d); check("R13 rx flush", d, 32'h0);

        // R7 zero count starts nothing
        wr(8'h18, TXB | RXB);
        rd(8'h14, d); check("R7 zero count", d, 32'h0);

        // R12 divider, R7 receive disabled stores nothing
        wr(8'h0C, 32'h3);
        wr(8'h20, 32'hA5);
        wr(8'h18, TXB | 32'd1);
        while (!sclk) @(negedge clk);
        hi = 0; while (sclk) begin hi++; @(negedge clk); end
        lo = 0; while (!sclk) begin lo++; @(negedge clk); end
        check("R12 high phase", 32'(hi), 32'd4);
        check("R12 low phase", 32'(lo), 32'd4);
        wait_idle();
        rd(8'h14, d); check("R7 rx disabled", d, 32'h0);
        check("R12 data", 32'(cap), 32'hA5);

        // R1 reset mid-state
        wr(8'h28, 32'h3);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R1 cs after reset", 32'(cs_n), 32'hF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule